// File: doc/BRIEF.md
# Bus-master PRD DMA engine

This block is the data mover behind a disk controller's bus-master DMA channel. Software sets up a descriptor table in memory and loads its address into a pointer register. It picks the transfer direction and then sets the run bit. The engine reads each 8-byte descriptor through a simple memory read port. It then takes 16-bit words from a device stream (valid/ready) and stores them through a memory write port at consecutive addresses of the region that descriptor names. It moves from region to region until the region flagged as last is done.

Completion and faults are reported through a small status register and an interrupt line. The activity bit follows the engine itself. The error and interrupt bits stay set until software writes a 1 to them. Clearing the run bit aborts a transfer cleanly at a word boundary. The memory-to-device direction is stored but moves no data. A table that runs to its size limit without an end marker is treated as an error.

Top module: `busdma_prd_engine`

## Requirements
- R1: The command register (offset 0) keeps bit 0 (run) and bit 3 (direction, 1 = device to memory) and reads all other bits as 0. A write that takes bit 0 from 0 to 1 with bit 3 = 1 starts the engine, and ACT reads 1 on the next cycle.
- R2: The table pointer (offset 2) reads back with bits 2:0 forced to 0. A write to it while ACT = 1 leaves it unchanged.
- R3: Each descriptor is two 32-bit reads, at the cursor and at cursor+4, and the next descriptor sits at cursor+8. The first word is the region address, with bit 0 ignored. In the second word, bits 15:0 are the byte count, with bit 0 ignored and 0 meaning 65536 bytes, and bit 31 flags the last region.
- R4: Every device word accepted is written once, in arrival order, to the region address, then +2, +4 and so on, region after region.
- R5: When the last word of the flagged region has been written, ACT goes to 0, INT (status bit 2) goes to 1 and ERR stays 0.
- R6: The status register (offset 1) holds bit 0 ACT, bit 1 ERR and bit 2 INT. ERR and INT clear only on a write of 1 to their own bit, and a 0 leaves them alone. ACT cannot be written. A hardware set in the same cycle as a software clear leaves the bit at 1.
- R7: If TABLE_BYTES/8 descriptors (64 KB by default) complete without the last-region flag, ERR and INT both become 1 and ACT becomes 0. No descriptor read is ever issued at or beyond pointer + TABLE_BYTES.
- R8: Writing run = 0 while ACT = 1 lets any open memory handshake finish, then clears ACT. ERR and INT are not touched. No further memory request is raised and no further device word is accepted.
- R9: A start with direction 0 is stored in the command register, but ACT stays 0 and no memory request or device word is taken.
- R10: `irq` always equals the INT status bit.
- R11: A memory read or write request, once raised, keeps its address and data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mrd_req | output | 1 | Descriptor read request |
| mrd_addr | output | 32 | Descriptor read address |
| mrd_ack | input | 1 | Read acknowledge, with data valid in the same cycle |
| mrd_data | input | 32 | Descriptor read data |
| mwr_req | output | 1 | Memory write request |
| mwr_addr | output | 32 | Memory write byte address, always even |
| mwr_data | output | 16 | Memory write data word |
| mwr_ack | input | 1 | Write acknowledge |
| dev_valid | input | 1 | Device word available |
| dev_data | input | 16 | Device word |
| dev_ready | output | 1 | Engine accepts a device word this cycle |
| irq | output | 1 | Interrupt, copy of status INT |

## Verification
The case that matters is a software write-1-to-clear of INT landing on the same clock edge where the engine finishes the last region and sets INT. The bench forces this by writing 0x06 to the status register on every cycle while it polls ACT. It stops as soon as ACT reads 0, so the final clear and the completion always share one edge. It then expects INT = 1, ERR = 0 and `irq` high. A second pairing is a stop command that arrives while a word write is still open. Here the bench requires that write to finish at the address the model expects, and it checks that nothing is requested afterwards.

// File: rtl/busdma_pkg.sv
package busdma_pkg;

    typedef enum logic [1:0] {
        WK_IDLE    = 2'd0,
        WK_DESC_LO = 2'd1,
        WK_DESC_HI = 2'd2,
        WK_MOVE    = 2'd3
    } walk_state_e;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_PTR  = 2'd2;

    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;
    localparam int ST_ACT_BIT  = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_INT_BIT  = 2;
    localparam int DESC_EOT_BIT = 31;

endpackage

// File: rtl/busdma_regs.sv
module busdma_regs
    import busdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              act,
    input  logic              done_evt,
    input  logic              err_evt,
    output logic              run,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] tbl_ptr,
    output logic              irq
);

    localparam int PTR_LSB = 3;

    typedef struct packed {
        logic              run;
        logic              dir;
        logic [ADDR_W-1:0] ptr;
        logic              err;
        logic              intr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        start_pulse = 1'b0;
        if (reg_we && reg_addr == RA_CMD) begin
            regs_d.run  = reg_wdata[CMD_RUN_BIT];
            regs_d.dir  = reg_wdata[CMD_DIR_BIT];
            start_pulse = reg_wdata[CMD_RUN_BIT] && reg_wdata[CMD_DIR_BIT] && !regs_q.run;
        end
        if (reg_we && reg_addr == RA_PTR && !act) begin
            regs_d.ptr = {reg_wdata[ADDR_W-1:PTR_LSB], {PTR_LSB{1'b0}}};
        end
        if (reg_we && reg_addr == RA_STAT) begin
            if (reg_wdata[ST_ERR_BIT]) regs_d.err  = 1'b0;
            if (reg_wdata[ST_INT_BIT]) regs_d.intr = 1'b0;
        end
        if (err_evt) begin
            regs_d.err  = 1'b1;
            regs_d.intr = 1'b1;
        end
        if (done_evt) regs_d.intr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CMD: begin
                reg_rdata[CMD_RUN_BIT] = regs_q.run;
                reg_rdata[CMD_DIR_BIT] = regs_q.dir;
            end
            RA_STAT: begin
                reg_rdata[ST_ACT_BIT] = act;
                reg_rdata[ST_ERR_BIT] = regs_q.err;
                reg_rdata[ST_INT_BIT] = regs_q.intr;
            end
            RA_PTR:  reg_rdata = 32'(regs_q.ptr);
            default: reg_rdata = '0;
        endcase
    end

    assign run     = regs_q.run;
    assign tbl_ptr = regs_q.ptr;
    assign irq     = regs_q.intr;

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        act && $past(act) |-> $stable(regs_q.ptr)); // R2
    AST_DONE_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> regs_q.intr); // R5
    AST_FAULT_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> regs_q.err && regs_q.intr); // R7

endmodule

// File: rtl/busdma_walker.sv
module busdma_walker
    import busdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int TABLE_BYTES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start_pulse,
    input  logic [ADDR_W-1:0] tbl_ptr,
    output logic              act,
    output logic              done_evt,
    output logic              err_evt,
    output logic              mrd_req,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              mrd_ack,
    input  logic [31:0]       mrd_data,
    output logic              mwr_req,
    output logic [ADDR_W-1:0] mwr_addr,
    output logic [DATA_W-1:0] mwr_data,
    input  logic              mwr_ack,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready
);

    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int MAX_DESC   = TABLE_BYTES / DESC_BYTES;
    localparam int IDX_W      = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(MAX_DESC - 1);
    localparam logic [CNT_W-1:0]  FULL_WORDS = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        walk_state_e       state;
        logic [ADDR_W-1:0] cursor;
        logic [ADDR_W-1:0] waddr;
        logic [CNT_W-1:0]  words;
        logic              eot;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wbuf;
        logic              wpend;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  bus_busy;

    always_comb begin
        walk_d   = walk_q;
        done_evt = 1'b0;
        err_evt  = 1'b0;
        mrd_req  = (walk_q.state == WK_DESC_LO) || (walk_q.state == WK_DESC_HI);
        mrd_addr = (walk_q.state == WK_DESC_HI) ? walk_q.cursor + ADDR_W'(4) : walk_q.cursor;
        mwr_req  = walk_q.wpend;
        mwr_addr = walk_q.waddr;
        mwr_data = walk_q.wbuf;
        dev_ready = run && (walk_q.state == WK_MOVE) && (walk_q.words != '0) && !walk_q.wpend;
        bus_busy  = (mrd_req && !mrd_ack) || (walk_q.wpend && !mwr_ack);

        case (walk_q.state)
            WK_IDLE: begin
                if (start_pulse) begin
                    walk_d.state  = WK_DESC_LO;
                    walk_d.cursor = tbl_ptr;
                    walk_d.idx    = '0;
                    walk_d.wpend  = 1'b0;
                end
            end
            WK_DESC_LO: begin
                if (mrd_ack) begin
                    walk_d.waddr = {mrd_data[ADDR_W-1:1], 1'b0};
                    walk_d.state = WK_DESC_HI;
                end
            end
            WK_DESC_HI: begin
                if (mrd_ack) begin
                    walk_d.eot   = mrd_data[DESC_EOT_BIT];
                    walk_d.words = (mrd_data[CNT_W-1:0] == '0) ? FULL_WORDS
                                                               : {1'b0, mrd_data[CNT_W-1:1]};
                    walk_d.state = WK_MOVE;
                end
            end
            WK_MOVE: begin
                if (walk_q.wpend) begin
                    if (mwr_ack) begin
                        walk_d.wpend = 1'b0;
                        walk_d.waddr = walk_q.waddr + ADDR_W'(WORD_BYTES);
                        walk_d.words = walk_q.words - CNT_W'(1);
                    end
                end else if (walk_q.words == '0) begin
                    if (walk_q.eot) begin
                        walk_d.state = WK_IDLE;
                        done_evt     = 1'b1;
                    end else if (walk_q.idx == LAST_IDX) begin
                        walk_d.state = WK_IDLE;
                        err_evt      = 1'b1;
                    end else begin
                        walk_d.idx    = walk_q.idx + IDX_W'(1);
                        walk_d.cursor = walk_q.cursor + ADDR_W'(DESC_BYTES);
                        walk_d.state  = WK_DESC_LO;
                    end
                end else if (dev_ready && dev_valid) begin
                    walk_d.wbuf  = dev_data;
                    walk_d.wpend = 1'b1;
                end
            end
            default: walk_d.state = WK_IDLE;
        endcase

        if (!run && walk_q.state != WK_IDLE && !bus_busy) begin
            walk_d.state = WK_IDLE;
            walk_d.wpend = 1'b0;
            done_evt     = 1'b0;
            err_evt      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign act = (walk_q.state != WK_IDLE);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req && !mrd_ack |=> mrd_req && $stable(mrd_addr)); // R11
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req && !mwr_ack |=> mwr_req && $stable(mwr_addr) && $stable(mwr_data)); // R11
    AST_WR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req |-> !mwr_addr[0]); // R4
    AST_STOPPED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !dev_ready); // R8

endmodule

// File: rtl/busdma_prd_engine.sv
module busdma_prd_engine
    import busdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 16,
    parameter int TABLE_BYTES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mrd_req,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              mrd_ack,
    input  logic [31:0]       mrd_data,
    output logic              mwr_req,
    output logic [ADDR_W-1:0] mwr_addr,
    output logic [DATA_W-1:0] mwr_data,
    input  logic              mwr_ack,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready,
    output logic              irq
);

    localparam int CNT_W = 16;

    logic              act;
    logic              done_evt;
    logic              err_evt;
    logic              run;
    logic              start_pulse;
    logic [ADDR_W-1:0] tbl_ptr;

    busdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .act         (act),
        .done_evt    (done_evt),
        .err_evt     (err_evt),
        .run         (run),
        .start_pulse (start_pulse),
        .tbl_ptr     (tbl_ptr),
        .irq         (irq)
    );

    busdma_walker #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .TABLE_BYTES (TABLE_BYTES)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .start_pulse (start_pulse),
        .tbl_ptr     (tbl_ptr),
        .act         (act),
        .done_evt    (done_evt),
        .err_evt     (err_evt),
        .mrd_req     (mrd_req),
        .mrd_addr    (mrd_addr),
        .mrd_ack     (mrd_ack),
        .mrd_data    (mrd_data),
        .mwr_req     (mwr_req),
        .mwr_addr    (mwr_addr),
        .mwr_data    (mwr_data),
        .mwr_ack     (mwr_ack),
        .dev_valid   (dev_valid),
        .dev_data    (dev_data),
        .dev_ready   (dev_ready)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !mrd_req && !mwr_req && !dev_ready); // R9
    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req |-> (mrd_addr - tbl_ptr) < ADDR_W'(TABLE_BYTES)); // R7

endmodule

// File: tb/test_busdma_prd_engine.sv
module test_busdma_prd_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_ack = 1'b0;
    logic [31:0] mrd_data = '0;
    logic        mwr_req;
    logic [31:0] mwr_addr;
    logic [15:0] mwr_data;
    logic        mwr_ack = 1'b0;
    logic        dev_valid = 1'b0;
    logic [15:0] dev_data = '0;
    logic        dev_ready;
    logic        irq;

    busdma_prd_engine i_busdma_prd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_ack(mwr_ack),
        .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural model state
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_base [$];
    int          exp_words [$];
    int          exp_off = 0;
    int          dev_idx = 0;
    int          wr_idx  = 0;
    int          rd_reqs = 0;
    bit          dev_fire = 1'b0;
    bit          dev_en = 1'b0;
    logic [31:0] cur_ptr = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] actual, input logic [31:0] expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    function automatic logic [15:0] word_of(input int k);
        return 16'(k * 7 + 3);
    endfunction

    // memory, device stream and per-cycle comparison, all away from the rising edge
    always @(negedge clk) begin
        if (dev_fire) dev_idx++;
        dev_valid = dev_en;
        dev_data  = word_of(dev_idx);
        mrd_ack   = mrd_req && !mrd_ack;
        mrd_data  = mem.exists(mrd_addr) ? mem[mrd_addr] : 32'h0;
        mwr_ack   = mwr_req && !mwr_ack;
        dev_fire  = dev_valid && dev_ready;
        if (mrd_req) begin
            rd_reqs++;
            chk((mrd_addr - cur_ptr) < 32'd65536, "R7 descriptor read inside table window", mrd_addr, cur_ptr);
        end
        if (mwr_req && mwr_ack) begin
            if (exp_base.size() == 0) begin
                chk(1'b0, "R4 write with no region pending", mwr_addr, 32'hFFFF_FFFF);
            end else begin
                chk(mwr_addr === exp_base[0] + 32'(2 * exp_off), "R4 write address", mwr_addr,
                    exp_base[0] + 32'(2 * exp_off));
                chk(mwr_data === word_of(wr_idx), "R4 write data order", 32'(mwr_data), 32'(word_of(wr_idx)));
                exp_off++;
                if (exp_off == exp_words[0]) begin
                    void'(exp_base.pop_front());
                    void'(exp_words.pop_front());
                    exp_off = 0;
                end
            end
            wr_idx++;
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input int limit);
        logic [31:0] s;
        for (int i = 0; i < limit; i++) begin
            reg_rd(2'd1, s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        int before_wr, before_rd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_rd(2'd0, v); chk(v == 32'h0, "R1 command after reset", v, 32'h0);
        reg_rd(2'd1, v); chk(v == 32'h0, "R6 status after reset", v, 32'h0);
        reg_rd(2'd2, v); chk(v == 32'h0, "R2 pointer after reset", v, 32'h0);
        chk(irq == 1'b0, "R10 irq after reset", 32'(irq), 32'h0);
        chk({mrd_req, mwr_req, dev_ready} == 3'b000, "R9 quiet after reset",
            32'({mrd_req, mwr_req, dev_ready}), 32'h0);

        // pointer alignment
        reg_wr(2'd2, 32'h0000_1007);
        reg_rd(2'd2, v); chk(v == 32'h0000_1000, "R2 pointer low bits forced", v, 32'h0000_1000);
        cur_ptr = 32'h0000_1000;

        // two regions, odd base and odd count, with clear colliding with completion
        mem[32'h1000] = 32'h0000_2001; mem[32'h1004] = 32'h0000_0006;
        mem[32'h1008] = 32'h0000_3000; mem[32'h100C] = 32'h8000_0005;
        exp_base.push_back(32'h2000); exp_words.push_back(3);
        exp_base.push_back(32'h3000); exp_words.push_back(2);
        dev_en = 1'b1;
        before_wr = wr_idx;
        reg_wr(2'd0, 32'h0000_00F8);
        reg_rd(2'd0, v); chk(v == 32'h8, "R1 command keeps only run and direction", v, 32'h8);
        reg_wr(2'd0, 32'h0000_0009);
        reg_rd(2'd1, v); chk(v[0] == 1'b1, "R1 ACT after start", v, 32'h1);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            reg_we = 1'b0; reg_addr = 2'd1;
            #1;
            if (!reg_rdata[0]) break;
            reg_we = 1'b1; reg_wdata = 32'h6;
        end
        reg_we = 1'b0;
        reg_rd(2'd1, v);
        chk(v == 32'h4, "R6 completion set beats same-cycle clear", v, 32'h4);
        chk(v[0] == 1'b0 && v[2] == 1'b1 && v[1] == 1'b0, "R5 end-of-table status", v, 32'h4);
        chk(irq == 1'b1, "R10 irq follows INT set", 32'(irq), 32'h1);
        chk(wr_idx - before_wr == 5, "R3 odd count and base decode word total", 32'(wr_idx - before_wr), 32'd5);
        chk(exp_base.size() == 0, "R4 all regions written", 32'(exp_base.size()), 32'h0);

        // write-1-to-clear
        reg_wr(2'd1, 32'h0);
        reg_rd(2'd1, v); chk(v == 32'h4, "R6 writing zero keeps INT", v, 32'h4);
        reg_wr(2'd1, 32'h3);
        reg_rd(2'd1, v); chk(v == 32'h4, "R6 ACT not writable and ERR clear leaves INT", v, 32'h4);
        reg_wr(2'd1, 32'h4);
        reg_rd(2'd1, v); chk(v == 32'h0, "R6 INT cleared by writing one", v, 32'h0);
        chk(irq == 1'b0, "R10 irq follows INT clear", 32'(irq), 32'h0);

        // memory-to-device direction
        reg_wr(2'd0, 32'h0);
        before_rd = rd_reqs; before_wr = wr_idx;
        reg_wr(2'd0, 32'h1);
        reg_rd(2'd0, v); chk(v == 32'h1, "R9 direction zero start stored", v, 32'h1);
        repeat (10) @(negedge clk);
        reg_rd(2'd1, v); chk(v[0] == 1'b0, "R9 no activity for direction zero", v, 32'h0);
        chk(rd_reqs == before_rd && dev_idx == before_wr, "R9 no memory or device traffic",
            32'(rd_reqs - before_rd), 32'h0);

        // stop mid-region, pointer frozen while active
        mem[32'h4000] = 32'h0000_5000; mem[32'h4004] = 32'h8000_0000;
        reg_wr(2'd2, 32'h4000); cur_ptr = 32'h4000;
        exp_base.push_back(32'h5000); exp_words.push_back(32768);
        before_wr = wr_idx;
        reg_wr(2'd0, 32'h8);
        reg_wr(2'd0, 32'h9);
        repeat (20) @(negedge clk);
        reg_wr(2'd2, 32'h9000);
        reg_rd(2'd2, v); chk(v == 32'h4000, "R2 pointer write ignored while active", v, 32'h4000);
        reg_wr(2'd0, 32'h8);
        wait_idle(50);
        reg_rd(2'd1, v); chk(v == 32'h0, "R8 stop clears ACT without INT", v, 32'h0);
        before_rd = rd_reqs;
        v = 32'(wr_idx);
        repeat (10) @(negedge clk);
        chk(32'(wr_idx) == v && rd_reqs == before_rd && !mwr_req, "R8 no traffic after stop",
            32'(wr_idx), v);
        chk(wr_idx > before_wr && wr_idx - before_wr < 32768, "R8 stop cut region short",
            32'(wr_idx - before_wr), 32'd1);
        chk(dev_idx == wr_idx, "R8 every accepted word written", 32'(dev_idx), 32'(wr_idx));
        exp_base.delete(); exp_words.delete(); exp_off = 0;

        // zero count means 65536 bytes
        exp_base.push_back(32'h5000); exp_words.push_back(32768);
        before_wr = wr_idx;
        reg_wr(2'd0, 32'h9);
        wait_idle(100000);
        reg_rd(2'd1, v); chk(v == 32'h4, "R5 completion of full-size region", v, 32'h4);
        chk(wr_idx - before_wr == 32768, "R3 zero count moves 65536 bytes",
            32'(wr_idx - before_wr), 32'd32768);
        reg_wr(2'd1, 32'h4);

        // table limit without end marker
        cur_ptr = 32'h0010_0000;
        for (int i = 0; i < 8192; i++) begin
            mem[cur_ptr + 32'(8 * i)]     = 32'h0040_0000 + 32'(4 * i);
            mem[cur_ptr + 32'(8 * i + 4)] = 32'h0000_0002;
            exp_base.push_back(32'h0040_0000 + 32'(4 * i));
            exp_words.push_back(1);
        end
        mem[cur_ptr + 32'd65536] = 32'h0050_0000;
        mem[cur_ptr + 32'd65540] = 32'h8000_0002;
        reg_wr(2'd2, cur_ptr);
        before_wr = wr_idx;
        reg_wr(2'd0, 32'h8);
        reg_wr(2'd0, 32'h9);
        wait_idle(100000);
        reg_rd(2'd1, v); chk(v == 32'h6, "R7 table overrun sets ERR and INT", v, 32'h6);
        chk(wr_idx - before_wr == 8192, "R7 one word per descriptor up to limit",
            32'(wr_idx - before_wr), 32'd8192);
        chk(irq == 1'b1, "R10 irq on fault", 32'(irq), 32'h1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog expired actual=%0d expected=finish", WATCHDOG);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule